// File: doc/BRIEF.md
# Pulse-Width Bit Receiver with Group Watchdog

This block receives a short group of bits (1 up to `MAX_BITS`) from a single-wire bus. Each bit starts with a low interval and ends with a high interval. The bit's value depends on how long the line stays low. The receiver synchronises the line and finds its edges. It measures each low interval in timer ticks and compares the interval with a fixed threshold. A short low interval gives a 1 and a long one gives a 0. The decoded bit is shifted into a value register, and a count of the ones received is kept beside it for a later parity check.

A start strobe arms the receiver and sets how many bits to collect. When that many bits have arrived, a one-cycle valid pulse is raised. A watchdog runs across the whole group. Its window is 110% of the nominal group length, which is the bit count times the nominal bit length in ticks. If the group is still open when the window has passed, reception is abandoned, the value and the ones count are cleared, and a timeout pulse is raised instead of valid.

The tick rate, the decision threshold and the nominal bit length are parameters. They are set from the system clock and the wanted bus timing.

Top module: `pwr_bit_rx`

## Requirements
- R1: After synchronous reset, `value_o` and `ones_o` are zero and `valid_o` and `timeout_o` are low.
- R2: A bit is decoded as 1 when its low interval on the synchronised line is shorter than `THRESH_TICKS` ticks, and as 0 otherwise. The interval runs from the falling edge to the next rising edge.
- R3: Bits enter MSB-first. The value register shifts left and each new bit enters at bit 0. After an n-bit group the bits sit in `value_o[n-1:0]`, with the first bit received in bit n-1 and the upper bits zero.
- R4: `ones_o` equals the number of 1 bits received so far in the current group.
- R5: `nbits_i` is sampled with `start_i`. The values 1 to `MAX_BITS` select that bit count. A value of 0, or any value above `MAX_BITS`, selects `MAX_BITS`.
- R6: On the rising edge that ends the last bit, `valid_o` rises for exactly one cycle, three clock cycles after the line input goes high. `value_o` and `ones_o` then hold until the next start.
- R7: The limit is L = floor(`BIT_TICKS` * 11 * n / 10) ticks. If more than L ticks pass after the start strobe is sampled without the group completing, `timeout_o` pulses for one cycle. This happens L+2 cycles after the start edge when one tick is one clock. `value_o` and `ones_o` read zero and `valid_o` stays low.
- R8: `start_i` clears `value_o` and `ones_o` on the next edge and begins a new group. This also applies during a group in progress, and a low interval already under way when the start arrives is ignored.
- R9: Line activity while no group is open leaves `value_o`, `ones_o` and `valid_o` unchanged.
- R10: `valid_o` and `timeout_o` are never high in the same cycle. When a group completes in the cycle its watchdog would expire, completion wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| line_i | input | 1 | Bus line level, asynchronous (1 = idle/high) |
| start_i | input | 1 | One-cycle strobe that arms a new group |
| nbits_i | input | $clog2(MAX_BITS+1) | Requested bit count, sampled with start_i |
| value_o | output | MAX_BITS | Assembled bits, MSB-first |
| ones_o | output | $clog2(MAX_BITS+1) | Count of 1 bits in the group |
| valid_o | output | 1 | One-cycle pulse on normal completion |
| timeout_o | output | 1 | One-cycle pulse when the watchdog aborts the group |

## Verification
A change on `line_i` reaches the edge detector through two synchroniser flops. The result register then captures it on the following edge, so `valid_o` is due exactly three cycles after the line input goes high for the last bit. The bench notes a free-running cycle count when it drives that edge and compares it with the count at the first cycle `valid_o` is seen. The start strobe is counted from the edge that samples it, and `timeout_o` is due L+2 cycles later. The bench computes L from the bit count and compares the exact cycle. Outputs are sampled on the falling clock edge, so every registered result is settled when it is read.

// File: rtl/pwr_pkg.sv
// Package: shared helpers for the pulse-width bit receiver.
// Assumes: callers pass tick counts that fit in 32 bits.
package pwr_pkg;

    // Watchdog limit in ticks: 110% of the nominal group length, rounded down.
    function automatic int unsigned wd_limit(input int unsigned bit_ticks,
                                             input int unsigned nbits);
        return (bit_ticks * 11 * nbits) / 10;
    endfunction

endpackage

// File: rtl/pwr_tick_gen.sv
// Module: pwr_tick_gen
// Produces a one-cycle tick enable every DIV clock cycles; DIV of 1 gives a
// constant enable. Assumes DIV >= 1.
module pwr_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_q;

            // Free-running divider; the tick fires at the terminal count.
            always_ff @(posedge clk_i) begin
                if (!rst_ni)                          cnt_q <= '0;
                else if (cnt_q == CW'(DIV - 1))       cnt_q <= '0;
                else                                  cnt_q <= cnt_q + 1'b1;
            end

            assign tick_o = (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/pwr_line_sync.sv
// Module: pwr_line_sync
// Brings the asynchronous line into the clock domain with two flops and
// flags rising and falling edges of the synchronised level. Assumes the line
// idles high, so reset loads ones and no edge is seen out of reset.
module pwr_line_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic lvl_o,
    output logic fall_o,
    output logic rise_o
);
    logic [1:0] sync_q;
    logic       prev_q;

    // Two-stage synchroniser followed by a one-cycle history flop.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sync_q <= 2'b11;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            prev_q <= sync_q[1];
        end
    end

    assign lvl_o  = sync_q[1];
    assign fall_o = prev_q & ~sync_q[1];
    assign rise_o = ~prev_q & sync_q[1];
endmodule

// File: rtl/pwr_width_meter.sv
// Module: pwr_width_meter
// Counts ticks while the synchronised line is low and classifies the
// interval on the rising edge: shorter than THRESH ticks gives a 1. A
// strobe is produced only when the falling edge was seen while armed, so a
// low interval that began before arming is discarded. Assumes THRESH >= 1.
module pwr_width_meter #(
    parameter int THRESH = 208
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    input  logic clr_i,
    input  logic tick_i,
    input  logic lvl_i,
    input  logic fall_i,
    input  logic rise_i,
    output logic bit_stb_o,
    output logic bit_val_o
);
    localparam int WW = $clog2(THRESH + 1);

    logic [WW-1:0] wid_q;
    logic          seen_q;

    // Low-interval counter; restarts on a fall and saturates at the threshold.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wid_q <= '0;
        end else if (fall_i) begin
            wid_q <= tick_i ? WW'(1) : '0;
        end else if (!lvl_i && tick_i && (wid_q < WW'(THRESH))) begin
            wid_q <= wid_q + 1'b1;
        end
    end

    // Remembers that the current low interval began while armed.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i || !arm_i) seen_q <= 1'b0;
        else if (fall_i)                seen_q <= 1'b1;
        else if (rise_i)                seen_q <= 1'b0;
    end

    assign bit_stb_o = rise_i & seen_q & arm_i & ~clr_i;
    assign bit_val_o = (wid_q < WW'(THRESH));
endmodule

// File: rtl/pwr_bit_rx.sv
// Module: pwr_bit_rx (top)
// Collects a group of 1..MAX_BITS pulse-width coded bits MSB-first, counts
// the ones, and guards the group with a watchdog of 110% of its nominal
// length. Assumes MAX_BITS >= 2; tick-based parameters are in TICK_DIV units.
module pwr_bit_rx #(
    parameter int MAX_BITS     = 8,
    parameter int TICK_DIV     = 2,
    parameter int THRESH_TICKS = 208,
    parameter int BIT_TICKS    = 316,
    localparam int CW          = $clog2(MAX_BITS + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                line_i,
    input  logic                start_i,
    input  logic [CW-1:0]       nbits_i,
    output logic [MAX_BITS-1:0] value_o,
    output logic [CW-1:0]       ones_o,
    output logic                valid_o,
    output logic                timeout_o
);
    localparam int WD_MAX = (BIT_TICKS * 11 * MAX_BITS) / 10;
    localparam int WDW    = $clog2(WD_MAX + 2);

    logic                tick;
    logic                lvl, fall, rise;
    logic                bit_stb, bit_val;
    logic                busy_q;
    logic [MAX_BITS-1:0] sh_q;
    logic [CW-1:0]       ones_q, got_q, want_q, n_eff;
    logic [WDW-1:0]      wd_q, lim_q;
    logic                valid_q, tout_q;
    logic                last_bit, expired;

    pwr_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk_i (clk_i), .rst_ni (rst_ni), .tick_o (tick)
    );

    pwr_line_sync u_sync (
        .clk_i (clk_i), .rst_ni (rst_ni), .line_i (line_i),
        .lvl_o (lvl), .fall_o (fall), .rise_o (rise)
    );

    pwr_width_meter #(.THRESH(THRESH_TICKS)) u_meter (
        .clk_i (clk_i), .rst_ni (rst_ni), .arm_i (busy_q), .clr_i (start_i),
        .tick_i (tick), .lvl_i (lvl), .fall_i (fall), .rise_i (rise),
        .bit_stb_o (bit_stb), .bit_val_o (bit_val)
    );

    // Requested count with out-of-range values mapped to a full group.
    always_comb begin
        if (nbits_i == '0 || nbits_i > CW'(MAX_BITS)) n_eff = CW'(MAX_BITS);
        else                                          n_eff = nbits_i;
    end

    assign last_bit = bit_stb && (got_q + 1'b1 == want_q);
    assign expired  = (wd_q > lim_q);

    // Group sequencer: start, shift, complete or abort on watchdog expiry.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            busy_q  <= 1'b0;
            sh_q    <= '0;
            ones_q  <= '0;
            got_q   <= '0;
            want_q  <= '0;
            wd_q    <= '0;
            lim_q   <= '0;
            valid_q <= 1'b0;
            tout_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            tout_q  <= 1'b0;
            if (start_i) begin
                busy_q <= 1'b1;
                sh_q   <= '0;
                ones_q <= '0;
                got_q  <= '0;
                want_q <= n_eff;
                wd_q   <= '0;
                lim_q  <= WDW'(pwr_pkg::wd_limit(BIT_TICKS, 32'(n_eff)));
            end else if (busy_q) begin
                if (tick) wd_q <= wd_q + 1'b1;
                if (bit_stb) begin
                    sh_q   <= {sh_q[MAX_BITS-2:0], bit_val};
                    ones_q <= ones_q + CW'(bit_val);
                    got_q  <= got_q + 1'b1;
                end
                if (last_bit) begin
                    busy_q  <= 1'b0;
                    valid_q <= 1'b1;
                end else if (expired) begin
                    busy_q <= 1'b0;
                    sh_q   <= '0;
                    ones_q <= '0;
                    tout_q <= 1'b1;
                end
            end
        end
    end

    assign value_o   = sh_q;
    assign ones_o    = ones_q;
    assign valid_o   = valid_q;
    assign timeout_o = tout_q;
endmodule

// File: rtl/pwr_bit_rx_chk.sv
// Module: pwr_bit_rx_chk
// Temporal checks on the receiver's outputs, bound into every pwr_bit_rx.
module pwr_bit_rx_chk #(
    parameter int MAX_BITS = 8,
    localparam int CW      = $clog2(MAX_BITS + 1)
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                start_i,
    input logic                busy_i,
    input logic [MAX_BITS-1:0] value_i,
    input logic [CW-1:0]       ones_i,
    input logic                valid_i,
    input logic                timeout_i
);
    // R10: completion and abort never coincide.
    a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_i && timeout_i));

    // R6: valid is a single-cycle pulse.
    a_r6_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> !valid_i);

    // R7: an abort leaves value and ones cleared.
    a_r7_timeout_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_i |-> (value_i == '0 && ones_i == '0));

    // R8: a start clears value and ones on the next edge.
    a_r8_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (value_i == '0 && ones_i == '0));

    // R4: the ones count always matches the bits held in the value.
    a_r4_ones_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ones_i == CW'($countones(value_i)));

    // R9: with no group open and no start, the value does not move.
    a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_i && !start_i) |=> $stable(value_i));
endmodule

bind pwr_bit_rx pwr_bit_rx_chk #(.MAX_BITS(MAX_BITS)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .busy_i    (busy_q),
    .value_i   (value_o),
    .ones_i    (ones_o),
    .valid_i   (valid_o),
    .timeout_i (timeout_o)
);

// File: tb/pwr_bit_rx_tb.sv
// Directed bench for pwr_bit_rx: one tick per clock, threshold 26, bit 40.
module pwr_bit_rx_tb;
    localparam int MAXB = 8;
    localparam int CW   = $clog2(MAXB + 1);
    localparam int THR  = 26;
    localparam int BITL = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            line = 1'b1;
    logic            start = 1'b0;
    logic [CW-1:0]   nbits = '0;
    logic [MAXB-1:0] value;
    logic [CW-1:0]   ones;
    logic            valid, tout;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int s_cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwr_bit_rx #(.MAX_BITS(MAXB), .TICK_DIV(1), .THRESH_TICKS(THR),
                 .BIT_TICKS(BITL)) u_dut (
        .clk_i (clk), .rst_ni (rst_n), .line_i (line), .start_i (start),
        .nbits_i (nbits), .value_o (value), .ones_o (ones),
        .valid_o (valid), .timeout_o (tout)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start(input int n);
        @(negedge clk);
        start = 1'b1;
        nbits = CW'(n);
        @(negedge clk);
        start = 1'b0;
        s_cyc = cyc;
    endtask

    // Low for lo cycles, then high for hi cycles (hi = 0 leaves the line high).
    task automatic pulse(input int lo, input int hi);
        line = 1'b0;
        repeat (lo) @(negedge clk);
        line = 1'b1;
        repeat (hi) @(negedge clk);
    endtask

    // Sends the bits of pat MSB-first; the last one ends on its rising edge.
    task automatic send_bits(input int pat, input int n, output int rise_cyc);
        for (int i = n - 1; i >= 0; i--) begin
            if (i == 0) begin
                pulse(pat[0] ? 10 : 30, 0);
                rise_cyc = cyc;
            end else begin
                pulse(pat[i] ? 10 : 30, pat[i] ? 30 : 10);
            end
        end
    endtask

    // Waits up to lim cycles for valid; reports the cycle, and any timeout seen.
    task automatic wait_valid(input int lim, output int at, output int saw_to);
        at = -1;
        saw_to = 0;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if (tout) saw_to = 1;
            if (valid) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic t_reset();
        check("R1 value", int'(value), 0);
        check("R1 ones", int'(ones), 0);
        check("R1 valid", int'(valid), 0);
        check("R1 timeout", int'(tout), 0);
    endtask

    task automatic t_byte();
        int r, at, st;
        do_start(8);
        send_bits(8'hA5, 8, r);
        wait_valid(10, at, st);
        check("R6 valid latency", at - r, 3);
        check("R3 value MSB-first", int'(value), 8'hA5);
        check("R4 ones count", int'(ones), 4);
        check("R10 no timeout", st, 0);
        @(negedge clk);
        check("R6 valid one cycle", int'(valid), 0);
        check("R6 value held", int'(value), 8'hA5);
    endtask

    task automatic t_threshold();
        int r, at, st;
        do_start(2);
        pulse(THR - 1, 15);
        line = 1'b0;
        repeat (THR) @(negedge clk);
        line = 1'b1;
        r = cyc;
        wait_valid(10, at, st);
        check("R2 boundary valid", at - r, 3);
        check("R2 25 ticks=1, 26 ticks=0", int'(value), 2);
        check("R4 boundary ones", int'(ones), 1);
    endtask

    task automatic t_counts();
        int r, at, st;
        do_start(1);
        send_bits(1, 1, r);
        wait_valid(10, at, st);
        check("R5 single bit valid", at - r, 3);
        check("R5 single bit value", int'(value), 1);
        do_start(0);
        send_bits(8'h3C, 8, r);
        wait_valid(10, at, st);
        check("R5 count 0 means 8", int'(value), 8'h3C);
        check("R4 ones of 0x3C", int'(ones), 4);
    endtask

    task automatic t_idle();
        logic [MAXB-1:0] v0;
        logic [CW-1:0]   o0;
        int seen;
        v0 = value;
        o0 = ones;
        seen = 0;
        for (int k = 0; k < 3; k++) begin
            line = 1'b0;
            for (int j = 0; j < 10; j++) begin @(negedge clk); if (valid) seen = 1; end
            line = 1'b1;
            for (int j = 0; j < 10; j++) begin @(negedge clk); if (valid) seen = 1; end
        end
        check("R9 idle value", int'(value), int'(v0));
        check("R9 idle ones", int'(ones), int'(o0));
        check("R9 idle no valid", seen, 0);
    endtask

    task automatic t_timeout();
        int lim, at, sv;
        lim = (BITL * 11 * 2) / 10;
        do_start(2);
        pulse(10, 10);
        check("R7 partial value", int'(value), 1);
        at = -1;
        sv = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (valid) sv = 1;
            if (tout) begin
                at = cyc;
                break;
            end
        end
        check("R7 timeout cycle", at - s_cyc, lim + 2);
        check("R7 value cleared", int'(value), 0);
        check("R7 ones cleared", int'(ones), 0);
        check("R7 no valid", sv, 0);
    endtask

    task automatic t_restart();
        int r, at, st;
        do_start(8);
        pulse(10, 30);
        pulse(10, 30);
        pulse(10, 30);
        check("R8 before restart", int'(ones), 3);
        do_start(1);
        check("R8 value cleared", int'(value), 0);
        check("R8 ones cleared", int'(ones), 0);
        send_bits(1, 1, r);
        wait_valid(10, at, st);
        check("R8 new group valid", at - r, 3);
        check("R8 new group ones", int'(ones), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_byte();
        t_threshold();
        t_counts();
        t_idle();
        t_timeout();
        t_restart();
        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule